// File: doc/BRIEF.md
# Dual-Stage Compare Timer with Line-Code Output

The block is a programmable interval and waveform timer made of a 4-bit up counter and an 8-bit up counter. Each stage has its own compare value. The two stages work in one of two ways. Chained, they form a single 12-bit compare counter. Split, the 4-bit stage acts as a prescaler, and its compare match, after division in a duty-cycle generator, advances the 8-bit stage. A compare match drives a one-clock interrupt pulse and a toggle strobe for neighbouring blocks. It also drives an output stage built around one output flip-flop.

The output stage has several modes:
- toggle on every match,
- pulse mode, which toggles on both match and overflow,
- PWM with a compare value that is double-buffered up to overflow,
- a duty-gated output that shows the divider waveform,
- biphase or Manchester encoding of a serial bit presented on `ser_data`, with the half-bit timing set by the compare period.

Software programs the block through a nibble-wide write port. While the timer is halted, the output level is forced from a preset bit.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset every register holds all ones. The timer is halted, `tmr_out` is 1, and `irq` and `tog_strobe` are 0. Starting the timer with only the control register changed gives chained mode and toggle mode, and the first `irq` comes 4096 cycles after the start write.
- R2: Registers are written when `wr_en` is 1 on a rising clock edge: address 0 is control, 1 is output mode (bits 2:0), 2 is duty code (bits 1:0), 3 is the 4-bit compare, 4 is the low nibble of the 8-bit compare and 5 is its high nibble. Control bit 3 = halt (1 halts the timer and holds all counters at zero), bit 2 = preset level and bit 0 = chained mode. While halted, no `irq` is produced.
- R3: In chained mode (control bit 0 = 1) the 12-bit value {compare8, compare4} = C gives a match every C+1 cycles. The first `irq` is seen C+1 cycles after the edge that starts the timer.
- R4: In split mode (control bit 0 = 0) the match period is (compare4+1) × k × (compare8+1) cycles, where k is the divide ratio from the duty code.
- R5: Duty code 11 gives k=1, 10 gives k=2, 01 gives k=3 and 00 gives k=4. In output mode 010, `tmr_out` is high for one prescaler period out of every k while the output flip-flop is 1.
- R6: In output mode 111 each match inverts `tmr_out`. `irq` rises on the edge of each match and is one clock wide.
- R7: In output mode 110 the counter runs to its full count and wraps. `tmr_out` toggles at both match and overflow, `tog_strobe` pulses at both, and `irq` pulses only at the match.
- R8: In output mode 101 (PWM) the counter wraps at full count. Overflow sets `tmr_out` and a match clears it. A new compare value takes effect only at the next overflow.
- R9: In output mode 011 (Manchester), the first match of each bit cell drives `tmr_out` to `ser_data`. The next match inverts it.
- R10: In output mode 100 (biphase), the first match of each bit cell inverts `tmr_out`. The next match inverts it again only when `ser_data` is 1.
- R11: While halted, `tmr_out` follows the preset bit (control bit 2) from the cycle after it is written.
- R12: A write to address 4 only stages the low nibble. The 8-bit compare changes as a whole only on the following write to address 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 4 | Register write nibble |
| ser_data | input | 1 | Serial data bit to be line-coded |
| tmr_out | output | 1 | Timer output pin |
| tog_strobe | output | 1 | One-clock pulse on every output-stage event |
| irq | output | 1 | One-clock interrupt pulse per compare match |

## Verification
The assertions assume the following about the inputs:
- The duty code, mode bits and compare values change only while the timer is halted. The one exception is the PWM compare reload.
- The serial bit stays stable through each bit cell.
- In toggle mode the match period is at least two cycles, so an interrupt pulse can be seen to end.

The stimulus follows these rules: it reprograms the block only after a halt write, changes `ser_data` only just after the match that closes a bit cell, and uses compare values whose periods are above one.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [2:0] {
    OM_DUTY   = 3'b010,
    OM_MANCH  = 3'b011,
    OM_BIPH   = 3'b100,
    OM_PWM    = 3'b101,
    OM_PULSE  = 3'b110,
    OM_TOGGLE = 3'b111
  } omode_e;

  localparam int A_CTRL   = 0;
  localparam int A_OMODE  = 1;
  localparam int A_DUTY   = 2;
  localparam int A_CMP4   = 3;
  localparam int A_CMP8LO = 4;
  localparam int A_CMP8HI = 5;

  // last divider state for a duty code: 11->0, 10->1, 01->2, 00->3
  function automatic logic [1:0] dcg_last(input logic [1:0] code);
    return 2'd3 - code;
  endfunction

  // modes in which the counter runs to full count instead of reloading
  function automatic logic is_free_run(input omode_e m);
    return (m == OM_PWM) || (m == OM_PULSE);
  endfunction

endpackage

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
#(
  parameter int DW = 4,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            run,
  output logic            preset,
  output logic            cascade,
  output omode_e          omode,
  output logic [1:0]      duty,
  output logic [DW-1:0]   cmp_pre,
  output logic [2*DW-1:0] cmp_main
);
  localparam int MW = 2 * DW;

  logic [2:0]    ctrl_q;     // {halt, preset, chained}
  logic [2:0]    mode_q;
  logic [1:0]    duty_q;
  logic [DW-1:0] pre_q;
  logic [DW-1:0] lo_stage_q;
  logic [MW-1:0] main_q;
  logic          hit_lo;

  assign hit_lo = wr_en && (wr_addr == AW'(A_CMP8LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '1;
      mode_q     <= '1;
      duty_q     <= '1;
      pre_q      <= '1;
      lo_stage_q <= '1;
      main_q     <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(A_CTRL):   ctrl_q     <= {wr_data[3:2], wr_data[0]};
        AW'(A_OMODE):  mode_q     <= wr_data[2:0];
        AW'(A_DUTY):   duty_q     <= wr_data[1:0];
        AW'(A_CMP4):   pre_q      <= wr_data;
        AW'(A_CMP8LO): lo_stage_q <= wr_data;
        AW'(A_CMP8HI): main_q     <= {wr_data, lo_stage_q};
        default: ;
      endcase
    end
  end

  assign run      = !ctrl_q[2];
  assign preset   = ctrl_q[1];
  assign cascade  = ctrl_q[0];
  assign omode    = omode_e'(mode_q);
  assign duty     = duty_q;
  assign cmp_pre  = pre_q;
  assign cmp_main = main_q;

  // R12: staging the low nibble never disturbs the live compare value
  assert_lo_staged_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo |=> $stable(cmp_main));

endmodule

// File: rtl/dct_count.sv
module dct_count
  import dct_pkg::*;
#(
  parameter int PW = 4,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cascade,
  input  logic          free_run,
  input  logic [1:0]    duty,
  input  logic [PW-1:0] cmp_pre,
  input  logic [MW-1:0] cmp_main,
  output logic          ev_match,
  output logic          ev_ovf,
  output logic          dcg_level
);
  localparam int FW = PW + MW;

  logic [PW-1:0] cnt_pre_q;
  logic [MW-1:0] cnt_main_q;
  logic [1:0]    dcnt_q;
  logic [FW-1:0] cmp_act_q;
  logic [FW-1:0] cnt_full, cmp_static, cmp_use, cnt_top, cnt_next;
  logic          pre_hit, dcg_wrap, ev_adv, reload;

  assign cnt_full   = cascade ? {cnt_main_q, cnt_pre_q} : FW'(cnt_main_q);
  assign cmp_static = cascade ? {cmp_main, cmp_pre} : FW'(cmp_main);
  assign cmp_use    = free_run ? cmp_act_q : cmp_static;
  assign cnt_top    = cascade ? {FW{1'b1}} : FW'({MW{1'b1}});

  assign pre_hit  = (cnt_pre_q == cmp_pre);
  assign dcg_wrap = (dcnt_q == dcg_last(duty));
  assign ev_adv   = run && (cascade || (pre_hit && dcg_wrap));
  assign ev_match = ev_adv && (cnt_full == cmp_use);
  assign ev_ovf   = ev_adv && (cnt_full == cnt_top);
  assign reload   = ev_match && !free_run;
  assign cnt_next = reload ? '0 : cnt_full + 1'b1;

  assign dcg_level = (dcnt_q == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_pre_q  <= '0;
      cnt_main_q <= '0;
      dcnt_q     <= '0;
      cmp_act_q  <= '1;
    end else if (!run) begin
      cnt_pre_q  <= '0;
      cnt_main_q <= '0;
      dcnt_q     <= '0;
      cmp_act_q  <= cmp_static;
    end else begin
      if (ev_ovf) cmp_act_q <= cmp_static;
      if (cascade) begin
        {cnt_main_q, cnt_pre_q} <= cnt_next;
      end else begin
        cnt_pre_q <= pre_hit ? '0 : cnt_pre_q + 1'b1;
        if (pre_hit) dcnt_q <= dcg_wrap ? 2'd0 : dcnt_q + 2'd1;
        if (ev_adv) cnt_main_q <= cnt_next[MW-1:0];
      end
    end
  end

  // R2: a halted timer holds both stages at zero
  assert_halt_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_pre_q == '0) && (cnt_main_q == '0));

  // R3: a reloading match restarts the count from zero
  assert_match_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_match && !free_run && cascade) |=> ({cnt_main_q, cnt_pre_q} == '0));

  // R5: the divider never passes the last state of its ratio
  assert_dcg_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (dcnt_q <= dcg_last(duty)));

endmodule

// File: rtl/dct_outstage.sv
module dct_outstage
  import dct_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   preset,
  input  omode_e omode,
  input  logic   ser_data,
  input  logic   ev_match,
  input  logic   ev_ovf,
  input  logic   dcg_level,
  output logic   tmr_out,
  output logic   tog_strobe,
  output logic   irq
);
  logic m_q, half_q, irq_q, tog_q, free_ev;

  assign free_ev = ev_ovf && is_free_run(omode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q    <= 1'b1;
      half_q <= 1'b0;
      irq_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      irq_q <= ev_match;
      tog_q <= ev_match || free_ev;
      if (!run) begin
        m_q    <= preset;
        half_q <= 1'b0;
      end else begin
        case (omode)
          OM_PULSE: if (ev_match ^ ev_ovf) m_q <= !m_q;
          OM_PWM: begin
            if (ev_ovf)        m_q <= 1'b1;
            else if (ev_match) m_q <= 1'b0;
          end
          OM_BIPH: if (ev_match) begin
            half_q <= !half_q;
            if (!half_q || ser_data) m_q <= !m_q;
          end
          OM_MANCH: if (ev_match) begin
            half_q <= !half_q;
            m_q    <= half_q ? !m_q : ser_data;
          end
          default: if (ev_match) m_q <= !m_q;
        endcase
      end
    end
  end

  assign tmr_out    = (omode == OM_DUTY) ? (m_q && dcg_level) : m_q;
  assign tog_strobe = tog_q;
  assign irq        = irq_q;

  // R6: every match is reported on the next cycle
  assert_irq_after_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match |=> irq);

  // R8: overflow in PWM mode leaves the output high
  assert_pwm_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && omode == OM_PWM && ev_ovf) |=> (m_q || !run));

  // R11: a halted timer loads the preset level
  assert_preset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (m_q == $past(preset)));

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int DW = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          ser_data,
  output logic          tmr_out,
  output logic          tog_strobe,
  output logic          irq
);
  localparam int MW = 2 * DW;

  logic          run, preset, cascade, free_run;
  omode_e        omode;
  logic [1:0]    duty;
  logic [DW-1:0] cmp_pre;
  logic [MW-1:0] cmp_main;
  logic          ev_match, ev_ovf, dcg_level;

  assign free_run = is_free_run(omode);

  dct_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .preset(preset), .cascade(cascade), .omode(omode), .duty(duty),
    .cmp_pre(cmp_pre), .cmp_main(cmp_main)
  );

  dct_count #(.PW(DW), .MW(MW)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .cascade(cascade), .free_run(free_run),
    .duty(duty), .cmp_pre(cmp_pre), .cmp_main(cmp_main),
    .ev_match(ev_match), .ev_ovf(ev_ovf), .dcg_level(dcg_level)
  );

  dct_outstage u_out (
    .clk(clk), .rst_n(rst_n), .run(run), .preset(preset), .omode(omode),
    .ser_data(ser_data), .ev_match(ev_match), .ev_ovf(ev_ovf), .dcg_level(dcg_level),
    .tmr_out(tmr_out), .tog_strobe(tog_strobe), .irq(irq)
  );

  // R2: a halted timer raises no interrupt
  assert_no_irq_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> !ev_match);

endmodule

// File: tb/dual_cmp_timer_tb.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic ser_data = 1'b0;
  logic tmr_out, tog_strobe, irq;

  int checks = 0, errors = 0, cyc = 0;
  int rise_cnt = 0, fall_cnt = 0, cur_len = 0, last_hi = 0, last_lo = 0;
  int tog_cnt = 0, irq_cnt = 0;
  logic prev_out = 1'b1;

  always #4 clk = !clk;

  dual_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ser_data(ser_data), .tmr_out(tmr_out), .tog_strobe(tog_strobe), .irq(irq)
  );

  // {chained, duty, cmp4, cmp8}
  localparam logic [19:0] VEC [0:5] = '{
    20'h13300, 20'h13201, 20'h03007, 20'h02102, 20'h01201, 20'h00303
  };

  always @(negedge clk) begin
    tog_cnt += int'(tog_strobe);
    irq_cnt += int'(irq);
    if (tmr_out !== prev_out) begin
      if (tmr_out) begin last_lo = cur_len; rise_cnt++; end
      else begin last_hi = cur_len; fall_cnt++; end
      cur_len = 1;
    end else cur_len++;
    prev_out = tmr_out;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [3:0] d);
    step(); wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    step(); wr_en = 1'b0;
  endtask

  task automatic cfg(input logic c, input logic [1:0] d, input logic [3:0] p,
                     input logic [7:0] m, input logic [2:0] om, input logic pre);
    wr(0, {1'b1, pre, 1'b0, c});
    wr(1, {1'b0, om});
    wr(2, {2'b00, d});
    wr(3, p);
    wr(4, m[3:0]);
    wr(5, m[7:4]);
  endtask

  task automatic start(input logic c, input logic pre);
    wr(0, {1'b0, pre, 1'b0, c});
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin step(); n++; end while (!irq && n < 20000);
  endtask

  task automatic wait_rise();
    int r = rise_cnt; int n = 0;
    while (rise_cnt == r && n < 20000) begin step(); n++; end
  endtask

  task automatic wait_fall();
    int f = fall_cnt; int n = 0;
    while (fall_cnt == f && n < 20000) begin step(); n++; end
  endtask

  function automatic int ratio(input logic [1:0] d);
    case (d)
      2'b11: return 1;
      2'b10: return 2;
      2'b01: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_period(input logic c, input logic [1:0] d,
                                    input logic [3:0] p, input logic [7:0] m);
    if (c) return int'({m, p}) + 1;
    return (int'(p) + 1) * ratio(d) * (int'(m) + 1);
  endfunction

  initial begin
    int n, t0, i0;
    logic o1;
    repeat (3) step();
    chk("R1 tmr_out at reset", int'(tmr_out), 1);
    chk("R1 irq at reset", int'(irq), 0);
    chk("R1 tog_strobe at reset", int'(tog_strobe), 0);
    rst_n = 1'b1;
    n = 0;
    repeat (40) begin step(); n += int'(irq); end
    chk("R2 no irq while halted", n, 0);
    start(1'b1, 1'b1);
    wait_irq(n);
    chk("R1 first irq from reset values", n, 4096);

    // table of counting configurations in toggle mode
    foreach (VEC[i]) begin
      logic c; logic [1:0] d; logic [3:0] p; logic [7:0] m; int per;
      c = VEC[i][16]; d = VEC[i][13:12]; p = VEC[i][11:8]; m = VEC[i][7:0];
      per = exp_period(c, d, p, m);
      cfg(c, d, p, m, 3'b111, 1'b1);
      start(c, 1'b1);
      wait_irq(n);
      chk(c ? "R3 first match latency" : "R4 first match latency", n, per);
      chk("R6 output inverted on match", int'(tmr_out), 0);
      o1 = tmr_out;
      wait_irq(n);
      chk(c ? "R3 match period" : "R4 match period", n, per);
      chk("R6 output inverted again", int'(tmr_out), int'(!o1));
      step();
      chk("R6 irq one clock wide", int'(irq), 0);
    end

    // preset level while halted
    cfg(1'b1, 2'b11, 4'h3, 8'h00, 3'b111, 1'b0);
    step();
    chk("R11 preset low", int'(tmr_out), 0);
    wr(0, 4'b1101);
    step();
    chk("R11 preset high", int'(tmr_out), 1);

    // atomic compare commit
    cfg(1'b0, 2'b11, 4'h0, 8'h03, 3'b111, 1'b1);
    start(1'b0, 1'b1);
    wait_irq(n);
    chk("R12 base period", n, 4);
    wr(0, 4'b1100);
    wr(4, 4'h9);
    start(1'b0, 1'b1);
    wait_irq(n);
    chk("R12 low nibble alone has no effect", n, 4);
    wr(0, 4'b1100);
    wr(5, 4'h0);
    start(1'b0, 1'b1);
    wait_irq(n);
    chk("R12 committed after high nibble", n, 10);

    // duty-gated output
    cfg(1'b0, 2'b01, 4'h1, 8'hFF, 3'b010, 1'b1);
    start(1'b0, 1'b1);
    wait_fall(); wait_rise();
    chk("R5 divide by 3 low time", last_lo, 4);
    wait_fall();
    chk("R5 divide by 3 high time", last_hi, 2);
    cfg(1'b0, 2'b10, 4'h1, 8'hFF, 3'b010, 1'b1);
    start(1'b0, 1'b1);
    wait_fall(); wait_rise();
    chk("R5 divide by 2 low time", last_lo, 2);

    // PWM with compare reload at overflow
    cfg(1'b0, 2'b11, 4'h0, 8'd63, 3'b101, 1'b1);
    start(1'b0, 1'b1);
    wait_rise();
    wr(4, 4'hF);
    wr(5, 4'h7);
    wait_fall();
    chk("R8 old compare holds until overflow", last_hi, 64);
    wait_rise();
    chk("R8 low time", last_lo, 192);
    wait_fall();
    chk("R8 new compare after overflow", last_hi, 128);

    // pulse mode
    cfg(1'b0, 2'b11, 4'h0, 8'd63, 3'b110, 1'b1);
    start(1'b0, 1'b1);
    wait_rise();
    t0 = tog_cnt; i0 = irq_cnt;
    wait_fall();
    chk("R7 high time", last_hi, 64);
    wait_rise();
    chk("R7 low time", last_lo, 192);
    chk("R7 strobes per wrap", tog_cnt - t0, 2);
    chk("R7 irqs per wrap", irq_cnt - i0, 1);

    // Manchester: 1 then 0
    ser_data = 1'b1;
    cfg(1'b1, 2'b11, 4'h3, 8'h00, 3'b011, 1'b0);
    start(1'b1, 1'b0);
    wait_irq(n); chk("R9 bit 1 first half", int'(tmr_out), 1);
    wait_irq(n); chk("R9 bit 1 second half", int'(tmr_out), 0);
    ser_data = 1'b0;
    wait_irq(n); chk("R9 bit 0 first half", int'(tmr_out), 0);
    wait_irq(n); chk("R9 bit 0 second half", int'(tmr_out), 1);

    // biphase: 1 then 0
    ser_data = 1'b1;
    cfg(1'b1, 2'b11, 4'h3, 8'h00, 3'b100, 1'b0);
    start(1'b1, 1'b0);
    wait_irq(n); chk("R10 bit 1 start", int'(tmr_out), 1);
    wait_irq(n); chk("R10 bit 1 middle", int'(tmr_out), 0);
    ser_data = 1'b0;
    wait_irq(n); chk("R10 bit 0 start", int'(tmr_out), 1);
    wait_irq(n); chk("R10 bit 0 middle", int'(tmr_out), 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule